// File: doc/BRIEF.md
# Sleep and Wake-Up Controller

This block governs the low-power states of a small microcontroller core. The core raises a one-cycle sleep strobe; if the sleep-enable input is set at that moment, the controller captures a 2-bit mode code and withdraws clock enables from the CPU and from the peripheral groups that the chosen mode switches off. While asleep it listens only to the wake sources that the mode admits.

Once a wake source is accepted, the controller brings the core back in a fixed order. In the deepest mode it first waits out a start-up delay, picked by a select input, while every clock stays off. It then restores all clocks and holds the CPU for a fixed number of cycles. Finally it pulses either an interrupt-take output, which lets the core service the interrupt and continue after the sleep instruction, or a reset-vector output when the wake came from a reset source. On an ordinary interrupt wake no reset is issued, so register and memory contents survive. Entering either of the two lighter modes with the converter enabled also fires a one-cycle conversion-start pulse.

A single always-running clock `clk` drives the whole block. The slow watchdog oscillator arrives as a one-cycle tick, `slow_tick_i`.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: A sleep state is entered only on a cycle where `sleep_strobe_i` and `sleep_en_i` are both 1. A strobe with sleep-enable 0 leaves `cpu_clk_en_o` at 1.
- R2: The mode code is latched on entry: 00 selects light idle, 01 selects converter-quiet, 10 selects deep power-down, and 11 behaves as light idle. While running, all three enables are 1. While asleep, `cpu_clk_en_o` is 0. `timer_clk_en_o` is 1 only in light idle. `adc_clk_en_o` is 1 in light idle and in converter-quiet.
- R3: In light idle, any of these wakes the block: `irq_any_i`, `irq_ext_level_i`, `irq_pin_chg_i`, `irq_adc_done_i`, `wdt_timeout_i`, `ext_reset_i`. The hold phase begins on the cycle after the source is sampled.
- R4: In converter-quiet, `irq_any_i` is ignored. The other five sources wake the block as in R3.
- R5: In deep power-down, `irq_any_i` and `irq_adc_done_i` are ignored. `wdt_timeout_i` and `ext_reset_i` are accepted at once.
- R6: In deep power-down, `irq_ext_level_i` or `irq_pin_chg_i` is accepted only when it is present on two consecutive `slow_tick_i` samples. A tick that finds neither source present cancels a first sighting.
- R7: After a deep power-down wake is accepted, all enables stay 0 for exactly `SU_BASE << su_sel_i` cycles (16, 32, 64 or 128 by default) before the hold phase.
- R8: The hold phase lasts exactly `HOLD_CYC` (4) cycles. During it `cpu_hold_o` is 1 and all enables are 1. In the next cycle, which is a running cycle, exactly one one-cycle pulse follows on `irq_take_o` or on `rst_vec_o`.
- R9: A wake caused by `wdt_timeout_i` or `ext_reset_i` ends with `rst_vec_o`. Any other wake ends with `irq_take_o`, and `rst_vec_o` stays 0.
- R10: Entering light idle or converter-quiet with `adc_on_i` at 1 produces a one-cycle `adc_start_o` pulse in the first sleep cycle. Entering deep power-down, or entering with `adc_on_i` at 0, produces none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_strobe_i | input | 1 | One-cycle sleep instruction strobe |
| sleep_en_i | input | 1 | Sleep-enable bit |
| mode_i | input | 2 | Sleep mode code |
| adc_on_i | input | 1 | Converter is enabled |
| irq_any_i | input | 1 | Any other enabled interrupt (timer, comparator, ...) |
| irq_ext_level_i | input | 1 | Level-sensed external interrupt request |
| irq_pin_chg_i | input | 1 | Pin-change interrupt request |
| irq_adc_done_i | input | 1 | Conversion-complete interrupt request |
| wdt_timeout_i | input | 1 | Watchdog time-out (reset source) |
| ext_reset_i | input | 1 | External reset request |
| slow_tick_i | input | 1 | One-cycle tick of the watchdog oscillator |
| su_sel_i | input | SU_SEL_W | Start-up delay select |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| timer_clk_en_o | output | 1 | Timer/comparator group clock enable |
| adc_clk_en_o | output | 1 | Converter group clock enable |
| cpu_hold_o | output | 1 | CPU held after wake |
| irq_take_o | output | 1 | Pulse: begin interrupt service |
| rst_vec_o | output | 1 | Pulse: restart from reset vector |
| adc_start_o | output | 1 | Pulse: start a conversion |

## Verification
The bench tries each of the six wake sources in every one of the four mode codes. A wake-source mask that is wrong for any mode shows up as a hold phase that either comes too early or never comes. Deep-mode pin wakes are tried with a first sighting and then a tick that finds no source present. A qualifier that does not clear on that tick, or that accepts after one tick, starts the start-up window early, and the bench sees the hold phase inside the window. The start-up length is checked for all four select values and the hold length cycle by cycle, so an off-by-one counter moves the final pulse. Reset-type wakes are told apart from interrupt wakes by which pulse ends the sequence.

// File: rtl/pwr_sleep_pkg.sv
package pwr_sleep_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_SLEEP = 2'd1,
        ST_START = 2'd2,
        ST_HOLD  = 2'd3
    } pwr_state_e;

    typedef enum logic [1:0] {
        MD_IDLE  = 2'b00,
        MD_ADCNR = 2'b01,
        MD_PDOWN = 2'b10
    } pwr_mode_e;

    // Reserved code 11 folds onto light idle.
    function automatic pwr_mode_e decode_mode(input logic [1:0] code);
        case (code)
            2'b01:   return MD_ADCNR;
            2'b10:   return MD_PDOWN;
            default: return MD_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/pwr_wake_filter.sv
module pwr_wake_filter
    import pwr_sleep_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      armed_i,
    input  pwr_mode_e mode_i,
    input  logic      irq_any_i,
    input  logic      irq_ext_level_i,
    input  logic      irq_pin_chg_i,
    input  logic      irq_adc_done_i,
    input  logic      wdt_timeout_i,
    input  logic      ext_reset_i,
    input  logic      slow_tick_i,
    output logic      wake_o,
    output logic      wake_rst_o
);

    typedef struct packed {
        logic seen;
    } flt_t;

    flt_t d, q;
    logic rst_src;
    logic pin_src;

    always_comb begin
        rst_src = wdt_timeout_i | ext_reset_i;
        pin_src = irq_ext_level_i | irq_pin_chg_i;
        d       = q;
        wake_o  = 1'b0;

        // First sighting of a pin source on a slow tick is remembered;
        // a tick without it wipes the sighting.
        if (!armed_i) begin
            d.seen = 1'b0;
        end else if (slow_tick_i) begin
            d.seen = pin_src;
        end

        case (mode_i)
            MD_ADCNR: wake_o = pin_src | irq_adc_done_i | rst_src;
            MD_PDOWN: wake_o = rst_src | (slow_tick_i & pin_src & q.seen);
            default:  wake_o = irq_any_i | pin_src | irq_adc_done_i | rst_src;
        endcase

        wake_o     = wake_o & armed_i;
        wake_rst_o = rst_src;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/pwr_clk_gate.sv
module pwr_clk_gate
    import pwr_sleep_pkg::*;
(
    input  pwr_state_e state_i,
    input  pwr_mode_e  mode_i,
    output logic       cpu_en_o,
    output logic       timer_en_o,
    output logic       adc_en_o,
    output logic       hold_o
);

    logic awake;

    always_comb begin
        awake      = (state_i == ST_RUN) || (state_i == ST_HOLD);
        cpu_en_o   = awake;
        timer_en_o = awake || (mode_i == MD_IDLE);
        adc_en_o   = awake || (mode_i != MD_PDOWN);
        hold_o     = (state_i == ST_HOLD);
    end

endmodule

// File: rtl/pwr_sleep_ctrl.sv
module pwr_sleep_ctrl
    import pwr_sleep_pkg::*;
#(
    parameter int SU_BASE  = 16,
    parameter int SU_SEL_W = 2,
    parameter int HOLD_CYC = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sleep_strobe_i,
    input  logic                sleep_en_i,
    input  logic [1:0]          mode_i,
    input  logic                adc_on_i,
    input  logic                irq_any_i,
    input  logic                irq_ext_level_i,
    input  logic                irq_pin_chg_i,
    input  logic                irq_adc_done_i,
    input  logic                wdt_timeout_i,
    input  logic                ext_reset_i,
    input  logic                slow_tick_i,
    input  logic [SU_SEL_W-1:0] su_sel_i,
    output logic                cpu_clk_en_o,
    output logic                timer_clk_en_o,
    output logic                adc_clk_en_o,
    output logic                cpu_hold_o,
    output logic                irq_take_o,
    output logic                rst_vec_o,
    output logic                adc_start_o
);

    localparam int SU_MAX  = SU_BASE << ((1 << SU_SEL_W) - 1);
    localparam int CNT_MAX = (SU_MAX > HOLD_CYC) ? SU_MAX : HOLD_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        pwr_state_e       state;
        pwr_mode_e        mode;
        logic [CNT_W-1:0] cnt;
        logic             rst_wake;
        logic             adc_start;
        logic             irq_take;
        logic             rst_vec;
    } ctl_t;

    ctl_t      d, q;
    pwr_mode_e new_mode;
    logic      wake;
    logic      wake_rst;

    pwr_wake_filter u_filter (
        .clk             (clk),
        .rst_n           (rst_n),
        .armed_i         (q.state == ST_SLEEP),
        .mode_i          (q.mode),
        .irq_any_i       (irq_any_i),
        .irq_ext_level_i (irq_ext_level_i),
        .irq_pin_chg_i   (irq_pin_chg_i),
        .irq_adc_done_i  (irq_adc_done_i),
        .wdt_timeout_i   (wdt_timeout_i),
        .ext_reset_i     (ext_reset_i),
        .slow_tick_i     (slow_tick_i),
        .wake_o          (wake),
        .wake_rst_o      (wake_rst)
    );

    pwr_clk_gate u_gate (
        .state_i    (q.state),
        .mode_i     (q.mode),
        .cpu_en_o   (cpu_clk_en_o),
        .timer_en_o (timer_clk_en_o),
        .adc_en_o   (adc_clk_en_o),
        .hold_o     (cpu_hold_o)
    );

    always_comb begin
        new_mode    = decode_mode(mode_i);
        d           = q;
        d.adc_start = 1'b0;
        d.irq_take  = 1'b0;
        d.rst_vec   = 1'b0;

        case (q.state)
            ST_RUN: begin
                if (sleep_strobe_i && sleep_en_i) begin
                    d.state     = ST_SLEEP;
                    d.mode      = new_mode;
                    d.rst_wake  = 1'b0;
                    d.adc_start = adc_on_i && (new_mode != MD_PDOWN);
                end
            end
            ST_SLEEP: begin
                if (wake) begin
                    d.rst_wake = wake_rst;
                    if (q.mode == MD_PDOWN) begin
                        d.state = ST_START;
                        d.cnt   = CNT_W'((SU_BASE << su_sel_i) - 1);
                    end else begin
                        d.state = ST_HOLD;
                        d.cnt   = CNT_W'(HOLD_CYC - 1);
                    end
                end
            end
            ST_START: begin
                if (q.cnt == '0) begin
                    d.state = ST_HOLD;
                    d.cnt   = CNT_W'(HOLD_CYC - 1);
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            default: begin
                if (q.cnt == '0) begin
                    d.state    = ST_RUN;
                    d.irq_take = !q.rst_wake;
                    d.rst_vec  = q.rst_wake;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign irq_take_o  = q.irq_take;
    assign rst_vec_o   = q.rst_vec;
    assign adc_start_o = q.adc_start;

endmodule

// File: rtl/pwr_sleep_ctrl_chk.sv
module pwr_sleep_ctrl_chk #(
    parameter int HOLD_CYC = 4
) (
    input logic clk,
    input logic rst_n,
    input logic sleep_strobe_i,
    input logic sleep_en_i,
    input logic cpu_clk_en_o,
    input logic timer_clk_en_o,
    input logic adc_clk_en_o,
    input logic cpu_hold_o,
    input logic irq_take_o,
    input logic rst_vec_o,
    input logic adc_start_o
);

    logic [7:0] hold_seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_seen_q <= '0;
        end else if (cpu_hold_o) begin
            hold_seen_q <= hold_seen_q + 8'd1;
        end else begin
            hold_seen_q <= '0;
        end
    end

    assert_sleep_needs_enable_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_clk_en_o) |-> $past(sleep_strobe_i && sleep_en_i));

    assert_gate_nesting_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_clk_en_o && timer_clk_en_o) |-> adc_clk_en_o);

    assert_hold_length_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_hold_o) |-> (hold_seen_q == 8'(HOLD_CYC)));

    assert_hold_clocks_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_hold_o |-> (cpu_clk_en_o && timer_clk_en_o && adc_clk_en_o));

    assert_single_exit_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_hold_o) |-> (irq_take_o != rst_vec_o));

    assert_adc_start_asleep_R10: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start_o |-> (!cpu_clk_en_o && adc_clk_en_o && !cpu_hold_o));

endmodule

bind pwr_sleep_ctrl pwr_sleep_ctrl_chk #(.HOLD_CYC(HOLD_CYC)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .sleep_strobe_i (sleep_strobe_i),
    .sleep_en_i     (sleep_en_i),
    .cpu_clk_en_o   (cpu_clk_en_o),
    .timer_clk_en_o (timer_clk_en_o),
    .adc_clk_en_o   (adc_clk_en_o),
    .cpu_hold_o     (cpu_hold_o),
    .irq_take_o     (irq_take_o),
    .rst_vec_o      (rst_vec_o),
    .adc_start_o    (adc_start_o)
);

// File: tb/pwr_sleep_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwr_sleep_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep_strobe_i = 1'b0;
    logic       sleep_en_i = 1'b0;
    logic [1:0] mode_i = 2'b00;
    logic       adc_on_i = 1'b0;
    logic       irq_any_i = 1'b0;
    logic       irq_ext_level_i = 1'b0;
    logic       irq_pin_chg_i = 1'b0;
    logic       irq_adc_done_i = 1'b0;
    logic       wdt_timeout_i = 1'b0;
    logic       ext_reset_i = 1'b0;
    logic       slow_tick_i = 1'b0;
    logic [1:0] su_sel_i = 2'b00;
    logic       cpu_clk_en_o, timer_clk_en_o, adc_clk_en_o;
    logic       cpu_hold_o, irq_take_o, rst_vec_o, adc_start_o;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    pwr_sleep_ctrl dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .sleep_strobe_i  (sleep_strobe_i),
        .sleep_en_i      (sleep_en_i),
        .mode_i          (mode_i),
        .adc_on_i        (adc_on_i),
        .irq_any_i       (irq_any_i),
        .irq_ext_level_i (irq_ext_level_i),
        .irq_pin_chg_i   (irq_pin_chg_i),
        .irq_adc_done_i  (irq_adc_done_i),
        .wdt_timeout_i   (wdt_timeout_i),
        .ext_reset_i     (ext_reset_i),
        .slow_tick_i     (slow_tick_i),
        .su_sel_i        (su_sel_i),
        .cpu_clk_en_o    (cpu_clk_en_o),
        .timer_clk_en_o  (timer_clk_en_o),
        .adc_clk_en_o    (adc_clk_en_o),
        .cpu_hold_o      (cpu_hold_o),
        .irq_take_o      (irq_take_o),
        .rst_vec_o       (rst_vec_o),
        .adc_start_o     (adc_start_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // Source index: 0 other irq, 1 level, 2 pin change, 3 adc done, 4 watchdog, 5 ext reset
    task automatic set_src(input int s, input logic v);
        case (s)
            0: irq_any_i = v;
            1: irq_ext_level_i = v;
            2: irq_pin_chg_i = v;
            3: irq_adc_done_i = v;
            4: wdt_timeout_i = v;
            default: ext_reset_i = v;
        endcase
    endtask

    function automatic bit allowed(input int md, input int s);
        if (md == 1) return (s != 0);
        if (md == 2) return (s != 0) && (s != 3);
        return 1'b1;
    endfunction

    function automatic string mode_req(input int md);
        if (md == 1) return "R4";
        if (md == 2) return "R5";
        return "R3";
    endfunction

    task automatic enter(input int md, input bit adc);
        @(negedge clk);
        mode_i = 2'(md);
        adc_on_i = adc;
        sleep_en_i = 1'b1;
        sleep_strobe_i = 1'b1;
        @(negedge clk);
        sleep_strobe_i = 1'b0;
        chk("R1 cpu off after enabled strobe", int'(cpu_clk_en_o), 0);
        chk("R2 timer enable asleep", int'(timer_clk_en_o), int'(md == 0 || md == 3));
        chk("R2 adc enable asleep", int'(adc_clk_en_o), int'(md != 2));
        chk("R10 adc start pulse", int'(adc_start_o), int'(adc && md != 2));
        @(negedge clk);
        chk("R10 adc start one cycle", int'(adc_start_o), 0);
    endtask

    task automatic startup_wait(input int sel);
        for (int i = 0; i < (16 << sel); i++) begin
            chk("R7 startup no hold", int'(cpu_hold_o), 0);
            chk("R7 startup clocks off", int'(cpu_clk_en_o | timer_clk_en_o | adc_clk_en_o), 0);
            @(negedge clk);
        end
    endtask

    task automatic hold_seq(input bit rst);
        for (int i = 0; i < 4; i++) begin
            chk("R8 hold active", int'(cpu_hold_o), 1);
            chk("R8 clocks on in hold", int'(cpu_clk_en_o & timer_clk_en_o & adc_clk_en_o), 1);
            chk("R8 no pulse during hold", int'(irq_take_o | rst_vec_o), 0);
            @(negedge clk);
        end
        chk("R8 hold released", int'(cpu_hold_o), 0);
        chk("R9 irq take pulse", int'(irq_take_o), int'(!rst));
        chk("R9 reset vector pulse", int'(rst_vec_o), int'(rst));
        chk("R2 running cpu enable", int'(cpu_clk_en_o), 1);
        @(negedge clk);
        chk("R8 pulse one cycle", int'(irq_take_o | rst_vec_o), 0);
    endtask

    task automatic tick_pulse();
        @(negedge clk);
        slow_tick_i = 1'b1;
        @(negedge clk);
        slow_tick_i = 1'b0;
    endtask

    task automatic run_case(input int md, input int s, input int sel);
        bit pd;
        pd = (md == 2);
        su_sel_i = 2'(sel);
        enter(md, bit'(s % 2));
        @(negedge clk);
        set_src(s, 1'b1);
        if (pd && s < 4) begin
            slow_tick_i = 1'b1;
            @(negedge clk);
            slow_tick_i = 1'b0;
            @(negedge clk);
            slow_tick_i = 1'b1;
        end
        @(negedge clk);
        slow_tick_i = 1'b0;
        set_src(s, 1'b0);
        if (allowed(md, s)) begin
            if (pd) startup_wait(sel);
            else chk({mode_req(md), " wake starts hold"}, int'(cpu_hold_o), 1);
            hold_seq(s >= 4);
        end else begin
            for (int i = 0; i < 3; i++) begin
                chk({mode_req(md), " source ignored hold"}, int'(cpu_hold_o), 0);
                chk({mode_req(md), " source ignored cpu"}, int'(cpu_clk_en_o), 0);
                @(negedge clk);
            end
            ext_reset_i = 1'b1;
            @(negedge clk);
            ext_reset_i = 1'b0;
            if (pd) startup_wait(sel);
            hold_seq(1'b1);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 reset cpu enable", int'(cpu_clk_en_o), 1);
        chk("R2 reset timer enable", int'(timer_clk_en_o), 1);
        chk("R2 reset adc enable", int'(adc_clk_en_o), 1);
        chk("R8 reset hold", int'(cpu_hold_o), 0);
        chk("R9 reset pulses", int'(irq_take_o | rst_vec_o | adc_start_o), 0);

        // R1: strobe with enable low, and enable high without strobe
        sleep_en_i = 1'b0;
        adc_on_i = 1'b1;
        sleep_strobe_i = 1'b1;
        @(negedge clk);
        sleep_strobe_i = 1'b0;
        chk("R1 strobe without enable ignored", int'(cpu_clk_en_o), 1);
        chk("R1 no adc start without sleep", int'(adc_start_o), 0);
        sleep_en_i = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 enable without strobe ignored", int'(cpu_clk_en_o), 1);

        // Sweep of every mode code against every wake source
        for (int md = 0; md < 4; md++) begin
            for (int s = 0; s < 6; s++) begin
                run_case(md, s, (md + s) % 4);
            end
        end

        // R6: a tick without the pin source cancels the first sighting
        su_sel_i = 2'd0;
        enter(2, 1'b0);
        irq_pin_chg_i = 1'b1;
        tick_pulse();
        irq_pin_chg_i = 1'b0;
        tick_pulse();
        irq_pin_chg_i = 1'b1;
        tick_pulse();
        chk("R6 single sighting not accepted", int'(cpu_hold_o), 0);
        tick_pulse();
        irq_pin_chg_i = 1'b0;
        startup_wait(0);
        hold_seq(1'b0);

        // R6: pin source gone between two ticks is not accepted
        enter(2, 1'b0);
        irq_ext_level_i = 1'b1;
        tick_pulse();
        irq_ext_level_i = 1'b0;
        tick_pulse();
        tick_pulse();
        repeat (20) @(negedge clk);
        chk("R6 interrupted level not accepted", int'(cpu_hold_o), 0);
        wdt_timeout_i = 1'b1;
        @(negedge clk);
        wdt_timeout_i = 1'b0;
        startup_wait(0);
        hold_seq(1'b1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule